// File: doc/BRIEF.md
# Security-Gated APB Register File

This block is an APB completer holding two small banks of 32-bit registers. The address space is split in two by the four address bits above bit 7: when those bits read 4'hF the access targets the guarded bank meant for keys and configuration, and every other address targets the open bank. Each completing transfer is judged against the requester's security attribute and privilege attribute. When the realm option is built in, the judgement also uses the extra address-space bit alongside the security bit. The instruction/data hint bit of the protection bus plays no part in any judgement.

A refused transfer still completes as a normal zero-wait APB transfer. It answers with an error response, changes no register and returns all-zero read data. Every refusal is tallied in a saturating counter and latches a sticky flag. Both values can be read back through a status word in the open bank. Only a write from the Secure or Root space clears the flag.

Top module: `apb_guarded_regfile`

## Requirements
- R1: `pready` is always 1, and `pslverr` is 0 in every cycle that is not an access phase (`psel` and `penable` both high).
- R2: An access to the open bank (PADDR[11:8] != 4'hF) is accepted from every security space. The only exception is the privileged-only build (R5).
- R3: The space is decoded from {pnse, pprot[1]} as 00 Secure, 01 Non-secure, 10 Root, 11 Realm. Secure and Root are accepted in the guarded bank (PADDR[11:8] == 4'hF), and Non-secure and Realm are refused there. With the realm option off, pnse is ignored and only pprot[1] decides (0 Secure, 1 Non-secure).
- R4: pprot[2] never changes whether an access is accepted or refused.
- R5: In the privileged-only build, an access with pprot[0]=0 is refused at every address.
- R6: A refused write leaves every register unchanged, and `pslverr` is high in its access phase.
- R7: A refused read returns `prdata` equal to zero and `pslverr` high in its access phase.
- R8: An accepted write stores `pwdata` at the clock edge that ends its access phase, and a later accepted read returns it. The layout is: open words at byte offsets 0x000, 0x004, 0x008, 0x00C; the status word at 0x010, with bits [7:0] the refusal count and bit 8 the sticky flag; guarded words at 0xF00, 0xF04, 0xF08, 0xF0C. Unmapped offsets read zero and ignore writes without an error.
- R9: Each refused transfer raises the 8-bit refusal count by one, and the count saturates at 255.
- R10: A refused transfer sets the sticky flag. An accepted write to the status word with bit 0 set clears the flag only when it comes from the Secure or Root space. From Non-secure or Realm such a write is accepted but leaves the flag set.
- R11: When a clear request is itself refused, the refusal wins: the flag stays set and the count advances.
- R12: After reset every register, the count and the flag read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| pprot | input | 3 | Protection attributes: [0] privileged, [1] non-secure, [2] instruction hint |
| pnse | input | 1 | Extra address-space bit used by the realm option |
| prdata | output | 32 | Read data, zero when refused |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Error response for a refused transfer |
| viol_count | output | 8 | Saturating refusal count |
| viol_sticky | output | 1 | Sticky refusal flag |

## Verification
Two functions can fall in the same cycle: a request to clear the sticky flag and a refusal that sets it. The bench provokes this by sending a clear write to the status word with pprot[0]=0 and pnse=1. The default build sees a Root write and clears the flag. The privileged-only build refuses the same write, so the flag must stay set and the count must advance. A second coincidence is a refusal arriving when the count is already 255. This is provoked by 300 back-to-back refused reads and judged by the status word: it must show 255 with the flag set.

// File: rtl/guard_pkg.sv
package guard_pkg;

    typedef enum logic [1:0] {
        SP_SECURE = 2'b00,
        SP_NONSEC = 2'b01,
        SP_ROOT   = 2'b10,
        SP_REALM  = 2'b11
    } space_e;

    typedef struct packed {
        logic   in_guard;
        logic   allow;
        logic   deny;
        logic   wr_en;
        logic   rd_en;
        logic   clr_ok;
        space_e space;
    } verdict_t;

endpackage

// File: rtl/guard_policy.sv
module guard_policy
    import guard_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int REGION_LSB = 8,
    parameter logic [ADDR_W-REGION_LSB-1:0] GUARD_TAG = '1,
    parameter bit REALM_EN   = 1'b1,
    parameter bit PRIV_ONLY  = 1'b0
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [1:0]        attr_lo,
    input  logic              nse,
    output verdict_t          verdict
);

    logic region_ok;
    logic priv_ok;
    logic complete;

    always_comb begin
        verdict          = '0;
        verdict.space    = space_e'({(REALM_EN ? nse : 1'b0), attr_lo[1]});
        verdict.in_guard = (paddr[ADDR_W-1:REGION_LSB] == GUARD_TAG);
        region_ok        = !verdict.in_guard
                         || (verdict.space == SP_SECURE)
                         || (verdict.space == SP_ROOT);
        priv_ok          = PRIV_ONLY ? attr_lo[0] : 1'b1;
        complete         = psel && penable;
        verdict.allow    = region_ok && priv_ok;
        verdict.deny     = complete && !verdict.allow;
        verdict.wr_en    = complete && pwrite && verdict.allow;
        verdict.rd_en    = psel && !pwrite && verdict.allow;
        verdict.clr_ok   = (verdict.space == SP_SECURE) || (verdict.space == SP_ROOT);
    end

endmodule

// File: rtl/guard_regbank.sv
module guard_regbank #(
    parameter int DATA_W = 32,
    parameter int N_REGS = 4,
    parameter int IDX_W  = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [N_REGS-1:0][DATA_W-1:0] regs_d;
    logic [N_REGS-1:0][DATA_W-1:0] regs_q;

    for (genvar g = 0; g < N_REGS; g++) begin : g_word
        assign regs_d[g] = (we && (idx == IDX_W'(g))) ? wdata : regs_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_REGS; i++) begin
            if (idx == IDX_W'(i)) begin
                rdata = regs_q[i];
            end
        end
    end

endmodule

// File: rtl/guard_viol_tracker.sv
module guard_viol_tracker #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             deny,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             sticky
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } trk_t;

    trk_t trk_d;
    trk_t trk_q;

    always_comb begin
        trk_d = trk_q;
        if (deny) begin
            if (trk_q.cnt != CNT_MAX) begin
                trk_d.cnt = trk_q.cnt + 1'b1;
            end
            trk_d.flag = 1'b1;
        end else if (clr) begin
            trk_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign count  = trk_q.cnt;
    assign sticky = trk_q.flag;

endmodule

// File: rtl/apb_guarded_regfile.sv
module apb_guarded_regfile
    import guard_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int REGION_LSB = 8,
    parameter logic [ADDR_W-REGION_LSB-1:0] GUARD_TAG = '1,
    parameter int N_OPEN     = 4,
    parameter int N_GUARD    = 4,
    parameter int CNT_W      = 8,
    parameter bit REALM_EN   = 1'b1,
    parameter bit PRIV_ONLY  = 1'b0
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [2:0]        pprot,
    input  logic              pnse,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic [CNT_W-1:0]  viol_count,
    output logic              viol_sticky
);

    localparam int WORD_W  = REGION_LSB - 2;
    localparam int OPEN_IW = (N_OPEN > 1) ? $clog2(N_OPEN) : 1;
    localparam int GRD_IW  = (N_GUARD > 1) ? $clog2(N_GUARD) : 1;

    verdict_t          verdict;
    logic [WORD_W-1:0] word;
    logic              open_hit;
    logic              stat_hit;
    logic              grd_hit;
    logic              open_we;
    logic              grd_we;
    logic              clr_req;
    logic [DATA_W-1:0] open_rd;
    logic [DATA_W-1:0] grd_rd;
    logic [DATA_W-1:0] stat_rd;
    logic [DATA_W-1:0] mux_rd;
    logic              unused_attr;

    assign unused_attr = ^{pprot[2], paddr[1:0]};

    guard_policy #(
        .ADDR_W     (ADDR_W),
        .REGION_LSB (REGION_LSB),
        .GUARD_TAG  (GUARD_TAG),
        .REALM_EN   (REALM_EN),
        .PRIV_ONLY  (PRIV_ONLY)
    ) policy_i (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .attr_lo (pprot[1:0]),
        .nse     (pnse),
        .verdict (verdict)
    );

    always_comb begin
        word     = paddr[REGION_LSB-1:2];
        open_hit = !verdict.in_guard && (word < WORD_W'(N_OPEN));
        stat_hit = !verdict.in_guard && (word == WORD_W'(N_OPEN));
        grd_hit  = verdict.in_guard && (word < WORD_W'(N_GUARD));
        open_we  = verdict.wr_en && open_hit;
        grd_we   = verdict.wr_en && grd_hit;
        clr_req  = verdict.wr_en && stat_hit && pwdata[0] && verdict.clr_ok;
    end

    guard_regbank #(
        .DATA_W (DATA_W),
        .N_REGS (N_OPEN),
        .IDX_W  (OPEN_IW)
    ) open_bank_i (
        .clk   (pclk),
        .rst_n (presetn),
        .we    (open_we),
        .idx   (word[OPEN_IW-1:0]),
        .wdata (pwdata),
        .rdata (open_rd)
    );

    guard_regbank #(
        .DATA_W (DATA_W),
        .N_REGS (N_GUARD),
        .IDX_W  (GRD_IW)
    ) guard_bank_i (
        .clk   (pclk),
        .rst_n (presetn),
        .we    (grd_we),
        .idx   (word[GRD_IW-1:0]),
        .wdata (pwdata),
        .rdata (grd_rd)
    );

    guard_viol_tracker #(
        .CNT_W (CNT_W)
    ) tracker_i (
        .clk    (pclk),
        .rst_n  (presetn),
        .deny   (verdict.deny),
        .clr    (clr_req),
        .count  (viol_count),
        .sticky (viol_sticky)
    );

    always_comb begin
        stat_rd = DATA_W'({viol_sticky, viol_count});
        if (open_hit) begin
            mux_rd = open_rd;
        end else if (stat_hit) begin
            mux_rd = stat_rd;
        end else if (grd_hit) begin
            mux_rd = grd_rd;
        end else begin
            mux_rd = '0;
        end
        prdata  = verdict.rd_en ? mux_rd : '0;
        pslverr = verdict.deny;
        pready  = 1'b1;
    end

endmodule

// File: rtl/guard_checker.sv
module guard_checker #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int REGION_LSB = 8,
    parameter logic [ADDR_W-REGION_LSB-1:0] GUARD_TAG = '1,
    parameter int CNT_W      = 8,
    parameter bit PRIV_ONLY  = 1'b0
) (
    input logic              pclk,
    input logic              presetn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [2:0]        pprot,
    input logic [DATA_W-1:0] prdata,
    input logic              pready,
    input logic              pslverr,
    input logic [CNT_W-1:0]  viol_count,
    input logic              viol_sticky
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    p_ready_high_r1: assert property (@(posedge pclk) disable iff (!presetn)
        pready);

    p_err_in_access_r1: assert property (@(posedge pclk) disable iff (!presetn)
        pslverr |-> (psel && penable));

    p_open_no_err_r2: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && !PRIV_ONLY && (paddr[ADDR_W-1:REGION_LSB] != GUARD_TAG))
        |-> !pslverr);

    p_secure_no_err_r3: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && !pprot[1] && (pprot[0] || !PRIV_ONLY)) |-> !pslverr);

    p_denied_rdata_zero_r7: assert property (@(posedge pclk) disable iff (!presetn)
        (pslverr && !pwrite) |-> (prdata == '0));

    p_count_step_r9: assert property (@(posedge pclk) disable iff (!presetn)
        (pslverr && (viol_count != CNT_MAX)) |=> (viol_count == CNT_W'($past(viol_count) + 1'b1)));

    p_count_sat_r9: assert property (@(posedge pclk) disable iff (!presetn)
        (viol_count == CNT_MAX) |=> (viol_count == CNT_MAX));

    p_count_hold_r9: assert property (@(posedge pclk) disable iff (!presetn)
        !pslverr |=> $stable(viol_count));

    p_err_sets_sticky_r10: assert property (@(posedge pclk) disable iff (!presetn)
        pslverr |=> viol_sticky);

endmodule

bind apb_guarded_regfile guard_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .REGION_LSB (REGION_LSB),
    .GUARD_TAG  (GUARD_TAG),
    .CNT_W      (CNT_W),
    .PRIV_ONLY  (PRIV_ONLY)
) checker_i (
    .pclk        (pclk),
    .presetn     (presetn),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .pprot       (pprot),
    .prdata      (prdata),
    .pready      (pready),
    .pslverr     (pslverr),
    .viol_count  (viol_count),
    .viol_sticky (viol_sticky)
);

// File: tb/apb_guarded_regfile_tb_top.sv
module apb_guarded_regfile_tb_top;

    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [2:0]  pprot = '0;
    logic        pnse = 1'b0;

    logic [31:0] prdata_a, prdata_b;
    logic        pready_a, pready_b;
    logic        pslverr_a, pslverr_b;
    logic [7:0]  cnt_a, cnt_b;
    logic        st_a, st_b;

    int n_chk = 0;
    int n_fail = 0;

    // model state, index 0: realm build, index 1: privileged-only build without realm
    logic [31:0] m_open [2][4];
    logic [31:0] m_grd  [2][4];
    int          m_cnt  [2];
    bit          m_st   [2];

    always #(CLK_P/2) clk = ~clk;

    apb_guarded_regfile dut_i (
        .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pprot(pprot),
        .pnse(pnse), .prdata(prdata_a), .pready(pready_a), .pslverr(pslverr_a),
        .viol_count(cnt_a), .viol_sticky(st_a)
    );

    apb_guarded_regfile #(.REALM_EN(1'b0), .PRIV_ONLY(1'b1)) dut_p (
        .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pprot(pprot),
        .pnse(pnse), .prdata(prdata_b), .pready(pready_b), .pslverr(pslverr_b),
        .viol_count(cnt_b), .viol_sticky(st_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit space_ok(input int c, input logic [2:0] pr, input logic ns);
        logic [1:0] sp;
        sp = (c == 0) ? {ns, pr[1]} : {1'b0, pr[1]};
        return (sp == 2'b00) || (sp == 2'b10);
    endfunction

    function automatic bit allow(input int c, input logic [11:0] a, input logic [2:0] pr, input logic ns);
        bit ok;
        ok = (a[11:8] != 4'hF) || space_ok(c, pr, ns);
        if (c == 1 && !pr[0]) ok = 0;
        return ok;
    endfunction

    function automatic logic [31:0] mread(input int c, input logic [11:0] a);
        int w;
        w = a[7:2];
        if (a[11:8] == 4'hF) return (w < 4) ? m_grd[c][w] : 32'h0;
        if (w < 4) return m_open[c][w];
        if (w == 4) return {23'h0, m_st[c], m_cnt[c][7:0]};
        return 32'h0;
    endfunction

    task automatic xfer(input bit w, input logic [11:0] a, input logic [31:0] d,
                        input logic [2:0] pr, input logic ns, input string tag);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d; pprot = pr; pnse = ns;
        #1;
        chk("R1", {31'h0, pslverr_a}, 32'h0);
        chk("R1", {31'h0, pslverr_b}, 32'h0);
        @(negedge clk);
        penable = 1'b1;
        #1;
        chk("R1", {30'h0, pready_a, pready_b}, 32'h3);
        for (int c = 0; c < 2; c++) begin
            bit ok;
            int wi;
            ok = allow(c, a, pr, ns);
            chk(tag, {31'h0, (c == 0) ? pslverr_a : pslverr_b}, {31'h0, !ok});
            if (!w) chk(tag, (c == 0) ? prdata_a : prdata_b, ok ? mread(c, a) : 32'h0);
            wi = a[7:2];
            if (!ok) begin
                if (m_cnt[c] < 255) m_cnt[c]++;
                m_st[c] = 1;
            end else if (w) begin
                if (a[11:8] == 4'hF) begin
                    if (wi < 4) m_grd[c][wi] = d;
                end else if (wi < 4) begin
                    m_open[c][wi] = d;
                end else if (wi == 4 && d[0] && space_ok(c, pr, ns)) begin
                    m_st[c] = 0;
                end
            end
        end
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    function automatic logic [11:0] addr_of(input int k);
        if (k < 5) return 12'(k * 4);
        if (k < 9) return 12'hF00 + 12'((k - 5) * 4);
        if (k == 9) return 12'h020;
        return 12'hF10;
    endfunction

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_cnt[c] = 0;
            m_st[c] = 0;
            for (int i = 0; i < 4; i++) begin
                m_open[c][i] = '0;
                m_grd[c][i] = '0;
            end
        end
        repeat (3) @(negedge clk);
        presetn = 1'b1;

        // R12: reset contents, read with secure privileged attributes
        for (int k = 0; k < 11; k++) xfer(1'b0, addr_of(k), 32'h0, 3'b001, 1'b0, "R12");

        // sweep every attribute combination over every address class
        for (int pr = 0; pr < 8; pr++) begin
            for (int ns = 0; ns < 2; ns++) begin
                for (int k = 0; k < 11; k++) begin
                    logic [11:0] a;
                    logic [31:0] d;
                    string ta;
                    a = addr_of(k);
                    d = 32'h5A00_0000 ^ (pr << 16) ^ (ns << 12) ^ (k << 4) ^ (k & 1);
                    if (pr[2]) ta = "R4";
                    else if (!pr[0]) ta = "R5";
                    else if (a[11:8] == 4'hF) ta = "R3";
                    else ta = "R2";
                    xfer(1'b1, a, d, 3'(pr), 1'(ns), ta);
                    xfer(1'b0, a, 32'h0, 3'(pr), 1'(ns), "R7");
                    xfer(1'b0, a, 32'h0, 3'b001, 1'b0, allow(0, a, 3'(pr), 1'(ns)) ? "R8" : "R6");
                end
            end
        end

        // R9: drive the counter to saturation with refused reads
        for (int i = 0; i < 300; i++) xfer(1'b0, 12'hF00, 32'h0, 3'b011, 1'b0, "R9");
        xfer(1'b0, 12'h010, 32'h0, 3'b001, 1'b0, "R9");
        chk("R9", {24'h0, cnt_a}, 32'd255);
        chk("R9", {24'h0, cnt_b}, 32'd255);

        // R10: non-secure clear is accepted but the flag stays set
        xfer(1'b1, 12'h010, 32'h1, 3'b011, 1'b0, "R10");
        xfer(1'b0, 12'h010, 32'h0, 3'b001, 1'b0, "R10");
        chk("R10", {31'h0, st_a}, 32'h1);

        // R11: root unprivileged clear: realm build clears, privileged-only build refuses
        xfer(1'b1, 12'h010, 32'h1, 3'b000, 1'b1, "R11");
        chk("R11", {31'h0, st_a}, 32'h0);
        chk("R11", {31'h0, st_b}, 32'h1);
        xfer(1'b0, 12'h010, 32'h0, 3'b001, 1'b0, "R11");

        // R10: secure privileged clear works on both builds
        xfer(1'b1, 12'h010, 32'h1, 3'b001, 1'b0, "R10");
        chk("R10", {31'h0, st_b}, 32'h0);
        xfer(1'b0, 12'h010, 32'h0, 3'b001, 1'b0, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule